// File: doc/BRIEF.md
# IF Zoom Downconverter and FFT Frame Feeder

This block sits between a two-bit intermediate-frequency sampler and a fixed-size FFT engine. Each incoming sample carries one sign bit and one magnitude bit. The block converts it to a signed value and then takes one of two paths. In direct mode the value goes straight to the output. In zoom mode the value is multiplied by a local carrier from a numerically controlled oscillator (NCO). A programmable number of these products is summed into one output sample, which narrows the band the FFT sees. The sum is shifted right by a programmable amount and clamped to the 8-bit input range of the FFT.

Both paths feed one output register that drives a valid/ready stream toward a FIFO. That stream marks the first and last sample of every 2048-sample frame. Software writes settings through a write strobe with an address. New settings are staged, and they take effect only when a frame starts, so every frame is computed with one consistent setting.

If the output register is still full when a new sample is produced, that sample is discarded. A sticky flag then records the loss.

Top module: `ifzoom_feeder`

## Requirements
- R1: Input code {sign, magnitude} maps to a signed value: 00 gives +1, 01 gives +3, 10 gives -1, 11 gives -3. In direct mode this value is the output sample, sign-extended to 8 bits.
- R2: In direct mode every input with `in_valid` high yields one output sample. That sample is presented with `out_valid` on the cycle after the input clock edge, provided the output slot is free.
- R3: Output samples are numbered in frames of FRAME_LEN (2048). `out_sof` marks the first sample of a frame and `out_eof` marks the last. Discarded samples are not counted.
- R4: The NCO phase is 32 bits wide and is zero after reset. It advances by the frequency word on every valid input, in either mode. Phase bits 31:29 select a carrier value from the sequence 3, 2, 0, -2, -3, -2, 0, 2 for indexes 0 to 7. Each product uses the phase as it stood before that input's advance.
- R5: In zoom mode, N consecutive products (sample times carrier) are summed into one output sample, and the sum is then cleared. A zoom factor of 0 behaves as 1.
- R6: In zoom mode the sum is arithmetically shifted right by 0 to 7 bits. The result is then saturated to the range -128 to +127.
- R7: Settings written to the registers are applied only at a frame boundary, meaning the point where no output of the current frame has been emitted and no products are pending. A frame is computed entirely under the settings in force when its first input arrives.
- R8: While `out_valid` is high and `out_ready` is low, the data and frame marks hold stable. A sample produced in that state is discarded.
- R9: `overrun` goes high when a sample is discarded and stays high until reset.
- R10: After reset the outputs are idle, `overrun` is low, and the settings are: direct mode, shift 0, zoom factor 1, frequency word 0.
- R11: Register map. Address 0: bit 0 selects zoom (1) or direct (0), and bits 6:4 hold the shift. Address 1 holds the 32-bit frequency word. Address 2: bits 15:0 hold the zoom factor. A write to address 3 has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample present |
| in_sign | input | 1 | Sample sign bit (1 = negative) |
| in_mag | input | 1 | Sample magnitude bit (1 = large) |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 32 | Register write data |
| out_valid | output | 1 | Output sample present |
| out_ready | input | 1 | Downstream accepts sample |
| out_data | output | 8 | Output sample, two's complement |
| out_sof | output | 1 | First sample of frame |
| out_eof | output | 1 | Last sample of frame |
| overrun | output | 1 | Sticky sample-loss flag |

## Verification
The hardest state to reach from the ports is a settings change that lands in the middle of a frame. Reaching it requires the whole remaining frame to finish under the old mode while the write sits staged, and then the next frame to switch cleanly with no leftover partial sum. The stimulus writes zoom settings about 500 samples into a direct frame, so the switch is seen at the boundary. It then drives long constant-code zoom frames with factor 15 to hit both saturation limits. The last phase randomises `out_ready` so that discarded samples occur, which must not disturb the frame numbering.

// File: rtl/ifz_pkg.sv
package ifz_pkg;

    localparam int PH_W    = 32;
    localparam int IDX_W   = 3;
    localparam int FAC_W   = 16;
    localparam int SH_W    = 3;
    localparam int OUT_W   = 8;
    localparam int SMP_W   = 3;
    localparam int PROD_W  = 2 * SMP_W;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_FREQ = 2'd1;
    localparam logic [1:0] ADDR_ZOOM = 2'd2;

    typedef logic signed [SMP_W-1:0] smp_t;
    typedef logic signed [OUT_W-1:0] out_t;

    typedef struct packed {
        logic              zoom;
        logic [SH_W-1:0]   shift;
        logic [FAC_W-1:0]  factor;
        logic [PH_W-1:0]   freq;
    } zcfg_t;

    localparam zcfg_t CFG_RESET = '{zoom: 1'b0, shift: '0, factor: FAC_W'(1), freq: '0};

    function automatic smp_t sm_to_tc(input logic sgn, input logic mag);
        smp_t v;
        v = mag ? smp_t'(3) : smp_t'(1);
        return sgn ? -v : v;
    endfunction

    function automatic smp_t carrier_lut(input logic [IDX_W-1:0] idx);
        case (idx)
            3'd0:    return smp_t'(3);
            3'd1:    return smp_t'(2);
            3'd2:    return smp_t'(0);
            3'd3:    return smp_t'(-2);
            3'd4:    return smp_t'(-3);
            3'd5:    return smp_t'(-2);
            3'd6:    return smp_t'(0);
            default: return smp_t'(2);
        endcase
    endfunction

endpackage

// File: rtl/ifz_cfg.sv
module ifz_cfg
    import ifz_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [1:0]  wr_addr,
    input  logic [31:0] wr_data,
    input  logic        at_bound,
    output zcfg_t       cfg_eff
);
    zcfg_t staged_q;
    zcfg_t active_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            staged_q <= CFG_RESET;
            active_q <= CFG_RESET;
        end else begin
            if (at_bound)
                active_q <= staged_q;
            if (wr_en) begin
                case (wr_addr)
                    ADDR_CTRL: begin
                        staged_q.zoom  <= wr_data[0];
                        staged_q.shift <= wr_data[4 +: SH_W];
                    end
                    ADDR_FREQ: staged_q.freq   <= wr_data[PH_W-1:0];
                    ADDR_ZOOM: staged_q.factor <= wr_data[FAC_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    assign cfg_eff = at_bound ? staged_q : active_q;

    // R7
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !at_bound |=> $stable(active_q));

endmodule

// File: rtl/ifz_nco.sv
module ifz_nco
    import ifz_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            adv,
    input  logic [PH_W-1:0] freq,
    output smp_t            carrier
);
    logic [PH_W-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (rst)
            phase_q <= '0;
        else if (adv)
            phase_q <= phase_q + freq;
    end

    assign carrier = carrier_lut(phase_q[PH_W-1 -: IDX_W]);

    // R4
    phase_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(phase_q));

endmodule

// File: rtl/ifz_combiner.sv
module ifz_combiner
    import ifz_pkg::*;
#(
    parameter int ACC_W = 24
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  smp_valid,
    input  smp_t  smp,
    input  smp_t  carrier,
    input  zcfg_t cfg,
    output logic  done,
    output out_t  result,
    output logic  idle
);
    localparam logic signed [ACC_W-1:0] POS_LIM = ACC_W'(127);
    localparam logic signed [ACC_W-1:0] NEG_LIM = -ACC_W'(128);

    logic signed [ACC_W-1:0]  acc_q;
    logic [FAC_W-1:0]         cnt_q;
    logic [FAC_W-1:0]         fac_eff;
    logic signed [PROD_W-1:0] prod;
    logic signed [ACC_W-1:0]  sum;
    logic signed [ACC_W-1:0]  shifted;
    logic                     last;
    out_t                     zoom_val;

    assign fac_eff = (cfg.factor == '0) ? FAC_W'(1) : cfg.factor;
    assign prod    = smp * carrier;
    assign sum     = acc_q + {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};
    assign shifted = sum >>> cfg.shift;
    assign last    = (cnt_q == fac_eff - FAC_W'(1));

    always_comb begin
        if (shifted > POS_LIM)
            zoom_val = out_t'(127);
        else if (shifted < NEG_LIM)
            zoom_val = out_t'(-128);
        else
            zoom_val = shifted[OUT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            cnt_q <= '0;
        end else if (smp_valid && cfg.zoom) begin
            if (last) begin
                acc_q <= '0;
                cnt_q <= '0;
            end else begin
                acc_q <= sum;
                cnt_q <= cnt_q + FAC_W'(1);
            end
        end
    end

    assign done   = smp_valid && (!cfg.zoom || last);
    assign result = cfg.zoom ? zoom_val : {{(OUT_W-SMP_W){smp[SMP_W-1]}}, smp};
    assign idle   = (cnt_q == '0);

    // R5
    count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q < fac_eff);

    // R5
    direct_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg.zoom |-> acc_q == '0);

endmodule

// File: rtl/ifz_framer.sv
module ifz_framer
    import ifz_pkg::*;
#(
    parameter int FRAME_LEN = 2048
) (
    input  logic clk,
    input  logic rst,
    input  logic push,
    input  out_t push_data,
    input  logic out_ready,
    output logic out_valid,
    output out_t out_data,
    output logic out_sof,
    output logic out_eof,
    output logic overrun,
    output logic pos_zero
);
    localparam int POS_W = $clog2(FRAME_LEN);
    localparam logic [POS_W-1:0] POS_LAST = POS_W'(FRAME_LEN - 1);

    logic [POS_W-1:0] pos_q;
    logic             slot_free;

    assign slot_free = !out_valid || out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q     <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
            out_sof   <= 1'b0;
            out_eof   <= 1'b0;
            overrun   <= 1'b0;
        end else begin
            if (push && slot_free) begin
                out_valid <= 1'b1;
                out_data  <= push_data;
                out_sof   <= (pos_q == '0);
                out_eof   <= (pos_q == POS_LAST);
                pos_q     <= (pos_q == POS_LAST) ? '0 : pos_q + POS_W'(1);
            end else if (out_valid && out_ready) begin
                out_valid <= 1'b0;
            end
            if (push && !slot_free)
                overrun <= 1'b1;
        end
    end

    assign pos_zero = (pos_q == '0);

    // R8
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data)
                                    && $stable(out_sof) && $stable(out_eof));

    // R9
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun);

    // R3
    sof_eof_excl_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !(out_sof && out_eof));

endmodule

// File: rtl/ifzoom_feeder.sv
module ifzoom_feeder
    import ifz_pkg::*;
#(
    parameter int FRAME_LEN = 2048,
    parameter int ACC_W     = 24
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic        in_sign,
    input  logic        in_mag,
    input  logic        cfg_we,
    input  logic [1:0]  cfg_addr,
    input  logic [31:0] cfg_wdata,
    output logic        out_valid,
    input  logic        out_ready,
    output logic [7:0]  out_data,
    output logic        out_sof,
    output logic        out_eof,
    output logic        overrun
);
    zcfg_t cfg_eff;
    smp_t  smp;
    smp_t  carrier;
    out_t  comb_val;
    out_t  frame_data;
    logic  comb_done;
    logic  comb_idle;
    logic  pos_zero;
    logic  at_bound;

    assign smp      = sm_to_tc(in_sign, in_mag);
    assign at_bound = pos_zero && comb_idle;
    assign out_data = frame_data;

    ifz_cfg u_cfg (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (cfg_we),
        .wr_addr  (cfg_addr),
        .wr_data  (cfg_wdata),
        .at_bound (at_bound),
        .cfg_eff  (cfg_eff)
    );

    ifz_nco u_nco (
        .clk     (clk),
        .rst     (rst),
        .adv     (in_valid),
        .freq    (cfg_eff.freq),
        .carrier (carrier)
    );

    ifz_combiner #(.ACC_W(ACC_W)) u_comb (
        .clk       (clk),
        .rst       (rst),
        .smp_valid (in_valid),
        .smp       (smp),
        .carrier   (carrier),
        .cfg       (cfg_eff),
        .done      (comb_done),
        .result    (comb_val),
        .idle      (comb_idle)
    );

    ifz_framer #(.FRAME_LEN(FRAME_LEN)) u_frm (
        .clk       (clk),
        .rst       (rst),
        .push      (comb_done),
        .push_data (comb_val),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_data  (frame_data),
        .out_sof   (out_sof),
        .out_eof   (out_eof),
        .overrun   (overrun),
        .pos_zero  (pos_zero)
    );

    // R2
    direct_latency_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid && !cfg_eff.zoom && (!out_valid || out_ready) |=> out_valid);

endmodule

// File: tb/ifzoom_feeder_tb.sv
module ifzoom_feeder_tb;
    localparam int FL = 2048;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0, in_sign = 1'b0, in_mag = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        out_valid, out_ready = 1'b1;
    logic [7:0]  out_data;
    logic        out_sof, out_eof, overrun;

    always #2.5 clk = ~clk;

    ifzoom_feeder u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sign(in_sign), .in_mag(in_mag),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_sof(out_sof), .out_eof(out_eof), .overrun(overrun)
    );

    int n_cmp = 0;
    int n_bad = 0;
    string scen = "R10";

    // reference model state
    int cosv [8] = '{3, 2, 0, -2, -3, -2, 0, 2};
    logic [31:0] m_ph, s_fr, a_fr;
    int s_zoom, s_sh, s_n, a_zoom, a_sh, a_n;
    int m_acc, m_cnt, m_pos, m_frames, m_dat;
    bit m_vld, m_sof, m_eof, m_ov;
    string m_tag = "R1";

    always @(posedge clk) begin
        bit free, emit;
        int s, p, ev, nn;
        if (rst) begin
            m_ph = '0; s_fr = '0; a_fr = '0;
            s_zoom = 0; s_sh = 0; s_n = 1; a_zoom = 0; a_sh = 0; a_n = 1;
            m_acc = 0; m_cnt = 0; m_pos = 0; m_vld = 0; m_sof = 0; m_eof = 0; m_ov = 0; m_dat = 0;
        end else begin
            free = !m_vld || out_ready;
            if (m_vld && out_ready) m_vld = 0;
            emit = 0; ev = 0;
            if (in_valid) begin
                if (m_pos == 0 && m_cnt == 0) begin
                    a_zoom = s_zoom; a_sh = s_sh; a_n = s_n; a_fr = s_fr;
                end
                s = in_mag ? 3 : 1;
                if (in_sign) s = -s;
                p = s * cosv[m_ph[31:29]];
                m_ph = m_ph + a_fr;
                if (a_zoom == 0) begin
                    emit = 1; ev = s; m_tag = "R1";
                end else begin
                    nn = (a_n == 0) ? 1 : a_n;
                    m_acc += p; m_cnt++;
                    if (m_cnt == nn) begin
                        ev = m_acc >>> a_sh;
                        if (ev > 127) ev = 127;
                        if (ev < -128) ev = -128;
                        emit = 1; m_acc = 0; m_cnt = 0; m_tag = "R5";
                    end
                end
            end
            if (emit) begin
                if (free) begin
                    m_vld = 1; m_dat = ev;
                    m_sof = (m_pos == 0); m_eof = (m_pos == FL - 1);
                    if (m_eof) m_frames++;
                    m_pos = (m_pos + 1) % FL;
                end else m_ov = 1;
            end
            if (cfg_we) begin
                case (cfg_addr)
                    2'd0: begin s_zoom = cfg_wdata[0]; s_sh = cfg_wdata[6:4]; end
                    2'd1: s_fr = cfg_wdata;
                    2'd2: s_n = cfg_wdata[15:0];
                    default: ;
                endcase
            end
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            n_cmp++;
            if (out_valid !== m_vld) begin
                n_bad++;
                $display("FAIL R8 valid (scen %s) actual=%0d expected=%0d", scen, out_valid, m_vld);
            end
            n_cmp++;
            if (overrun !== m_ov) begin
                n_bad++;
                $display("FAIL R9 overrun (scen %s) actual=%0d expected=%0d", scen, overrun, m_ov);
            end
            if (m_vld && out_valid) begin
                n_cmp++;
                if ($signed(out_data) != m_dat) begin
                    n_bad++;
                    $display("FAIL %s data (scen %s) actual=%0d expected=%0d", m_tag, scen, $signed(out_data), m_dat);
                end
                n_cmp++;
                if (out_sof !== m_sof || out_eof !== m_eof) begin
                    n_bad++;
                    $display("FAIL R3 sof/eof (scen %s) actual=%0d%0d expected=%0d%0d", scen, out_sof, out_eof, m_sof, m_eof);
                end
            end
        end
    end

    logic [15:0] lfsr = 16'hACE1;
    int pat = 0;
    bit rdy_rand = 0;

    task automatic step();
        @(negedge clk);
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        in_valid = (lfsr[2:0] != 3'd0);
        case (pat)
            1: begin in_sign = 1'b0; in_mag = 1'b1; end
            2: begin in_sign = 1'b1; in_mag = 1'b1; end
            default: begin in_sign = lfsr[5]; in_mag = lfsr[9]; end
        endcase
        out_ready = rdy_rand ? lfsr[7] : 1'b1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        in_valid = 1'b0; out_ready = 1'b1;
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic run_frames(input int k);
        int tgt;
        tgt = m_frames + k;
        while (m_frames < tgt) step();
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL R2 watchdog actual=running expected=finished");
        summary();
    end

    initial begin
        m_frames = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: reset state
        n_cmp++;
        if (out_valid !== 1'b0 || overrun !== 1'b0) begin
            n_bad++;
            $display("FAIL R10 reset actual=%0d%0d expected=00", out_valid, overrun);
        end
        rst = 1'b0;

        // R2 / R1 / R3: direct stream, one full frame then partway
        scen = "R2";
        run_frames(1);
        repeat (500) step();

        // R7: zoom settings written mid-frame, R4 carrier stepping one index per input
        scen = "R7";
        wr(2'd1, 32'h2000_0000);
        wr(2'd2, 32'd3);
        wr(2'd0, 32'h0000_0001);
        // R11: address 3 write has no effect
        wr(2'd3, 32'hFFFF_FFFF);
        run_frames(1);
        scen = "R4";
        run_frames(1);

        // R6: positive saturation, 15 products of +9
        scen = "R6";
        pat = 1;
        wr(2'd1, 32'h0);
        wr(2'd2, 32'd15);
        run_frames(1);
        // R6: negative saturation
        pat = 2;
        run_frames(1);
        // R6: shift by 2 on mixed data with moving carrier
        pat = 0;
        wr(2'd1, 32'h0C00_0000);
        wr(2'd0, 32'h0000_0021);
        run_frames(1);

        // R5: zoom factor 0 behaves as 1, plus R11 ignored address
        scen = "R11";
        wr(2'd2, 32'd0);
        wr(2'd3, 32'h0000_0000);
        run_frames(1);

        // R8 / R9: direct mode with random backpressure
        scen = "R8";
        wr(2'd0, 32'h0000_0000);
        rdy_rand = 1;
        run_frames(1);
        rdy_rand = 0;
        repeat (50) step();
        summary();
    end

endmodule